// File: doc/BRIEF.md
# Parallel Neighbourhood Read Address Generator

This block sits between a coordinate source and a matrix of banked sample memories. Samples are interleaved over the banks by the low bits of their indices. A sample at column `c` and row `r` lives in bank row `r mod LANES` and bank column `c mod LANES`. Its word address inside that bank is `(r div LANES) * ROW_STRIDE + (c div LANES)`, taken modulo the bank depth. The block takes one fixed-point coordinate per dimension. From it, it issues a distinct read address to every bank in the same cycle, so that the whole cubic (1-D, `LANES` samples) or bicubic (2-D, `LANES` x `LANES` samples) neighbourhood comes back in a single memory access.

Each coordinate splits into three fields. The fraction is carried along for the interpolator. The bits just above it select the address pattern. The remaining integer bits give the base word address. Each bank adds a small signed step, taken from a sliding window over a fixed step vector, to the base in every dimension. The vertical part is scaled by the row stride. The memories answer one cycle after the addresses leave. The block then rotates the bank-ordered words into neighbour order and registers them together with the two fractions and a valid flag.

Top module: `nbr_fetch_top`

## Requirements
- R1: While reset is held and after its release, before any request, `bankRdEn` and `outValid` are 0.
- R2: `bankRdEn` is 1 in the cycle after a cycle with `reqValid` = 1 and is 0 after a cycle without a request.
- R3: The integer part of a coordinate is `reqX[FRAC_W +: IDX_W]`. Its low `log2(LANES)` bits are `lo` and the bits above are `hi`. Bank column `j` gets the column term `hi + s`. With `t = j - lo + LANES - 1`, `s` is +1 when `t < LANES/2`, -1 when `t >= 3*LANES/2`, and 0 otherwise.
- R4: The address of bank `(i,j)`, at index `i*LANES + j` of `bankAddr`, is the column term of `j` plus `ROW_STRIDE` times the row term of `i`. The row term is built from `reqY` by the rule of R3. The result is taken modulo `2^ADDR_W`.
- R5: Output word `a*LANES + b` of `outSamples` is the sample at row `y-1+a` and column `x-1+b`, where `x` and `y` are the integer coordinates. It is taken from bank `((y-1+a) mod LANES, (x-1+b) mod LANES)`.
- R6: `outValid` rises two cycles after `bankRdEn`. Requests may arrive on consecutive cycles, and the block produces one neighbourhood per cycle, in request order.
- R7: `outFracX` and `outFracY` equal the fractional fields (the low `FRAC_W` bits) of the request whose samples appear with `outValid`.
- R8: Neighbourhoods at coordinate 0 and at the top of the coordinate range wrap around the bank depth by the same modular address rule, with no special case.
- R9: Without a request, no read is issued, `outValid` stays 0 and `outSamples`, `outFracX` and `outFracY` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A coordinate request is present |
| reqX | input | IDX_W+FRAC_W | Horizontal coordinate, fixed point |
| reqY | input | IDX_W+FRAC_W | Vertical coordinate, fixed point (unused when DIMS = 1) |
| bankRdEn | output | 1 | Read strobe for all banks |
| bankAddr | output | NBANK*ADDR_W | One read address per bank, bank `i*LANES+j` at slice `i*LANES+j` |
| bankData | input | NBANK*DATA_W | Read data, one cycle after `bankRdEn`, in bank order |
| outValid | output | 1 | Reordered neighbourhood is present |
| outSamples | output | NBANK*DATA_W | Neighbourhood in neighbour order |
| outFracX | output | FRAC_W | Horizontal fraction aligned with `outSamples` |
| outFracY | output | FRAC_W | Vertical fraction aligned with `outSamples` |

## Verification
The assertions assume that the banks return data exactly one cycle after `bankRdEn` and that `LANES` is a power of two. They rely on the step vector being non-increasing, so that neighbouring bank addresses differ by 0 or by minus one step in each dimension. The bench memory model meets this by answering every read on the following edge with a word that encodes the bank index and the address it received. A wrong address or a wrong rotation therefore shows up in the data. Requests sweep every combination of low bits in both dimensions, at bases that touch both ends of the coordinate range, and then run back to back.

// File: rtl/nbr_fetch_pkg.sv
package nbr_fetch_pkg;

  // strobes from the control path into the datapath registers
  typedef struct packed {
    logic launch;   // request accepted: load bank addresses
    logic align;    // read in flight: move pattern/fraction to data stage
    logic publish;  // data back: load reordered neighbourhood
  } stage_strobe_t;

  // Step vector entry at window position t (0 .. 2*lanes-2), two-bit signed:
  // 01 = +1, 00 = 0, 11 = -1.  Non-increasing in t.
  function automatic logic [1:0] window_step(int t, int lanes);
    if (t < lanes / 2)
      return 2'b01;
    else if (t >= lanes + lanes / 2)
      return 2'b11;
    else
      return 2'b00;
  endfunction

endpackage

// File: rtl/nbr_fetch_ctrl.sv
module nbr_fetch_ctrl
  import nbr_fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output stage_strobe_t strobe,
  output logic          bankRdEn,
  output logic          outValid
);

  logic addrLive;
  logic dataLive;
  logic outLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLive <= 1'b0;
      dataLive <= 1'b0;
      outLive  <= 1'b0;
    end else begin
      addrLive <= reqValid;
      dataLive <= addrLive;
      outLive  <= dataLive;
    end
  end

  always_comb begin
    strobe.launch  = reqValid;
    strobe.align   = addrLive;
    strobe.publish = dataLive;
  end

  assign bankRdEn = addrLive;
  assign outValid = outLive;

endmodule

// File: rtl/nbr_fetch_dp.sv
module nbr_fetch_dp
  import nbr_fetch_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int ROWS       = 4,
  parameter int IDX_W      = 10,
  parameter int FRAC_W     = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int ROW_STRIDE = 64,
  localparam int LB        = $clog2(LANES),
  localparam int NBANK     = ROWS * LANES,
  localparam int COORD_W   = IDX_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stage_strobe_t           strobe,
  input  logic [COORD_W-1:0]      reqX,
  input  logic [COORD_W-1:0]      reqY,
  output logic [NBANK*ADDR_W-1:0] bankAddr,
  input  logic [NBANK*DATA_W-1:0] bankData,
  output logic [NBANK*DATA_W-1:0] outSamples,
  output logic [FRAC_W-1:0]       outFracX,
  output logic [FRAC_W-1:0]       outFracY
);

  // request field split
  logic [IDX_W-1:0]    xInt, yInt;
  logic [LB-1:0]       xLow, yLow;
  logic [IDX_W-LB-1:0] xHigh, yHigh;

  assign xInt  = reqX[FRAC_W +: IDX_W];
  assign yInt  = reqY[FRAC_W +: IDX_W];
  assign xLow  = xInt[LB-1:0];
  assign yLow  = yInt[LB-1:0];
  assign xHigh = xInt[IDX_W-1:LB];
  assign yHigh = yInt[IDX_W-1:LB];

  logic [ADDR_W-1:0] colTerm [LANES];
  logic [ADDR_W-1:0] rowTerm [ROWS];

  // horizontal terms: base plus windowed step
  for (genvar j = 0; j < LANES; j++) begin : g_col
    logic [1:0] colStep;
    always_comb begin
      colStep    = window_step(j - int'(xLow) + LANES - 1, LANES);
      colTerm[j] = ADDR_W'(xHigh) + {{(ADDR_W-2){colStep[1]}}, colStep};
    end
  end

  // vertical terms: same window rule, scaled by the bank row stride
  if (ROWS == 1) begin : g_row_flat
    assign rowTerm[0] = '0;
  end else begin : g_row_grid
    for (genvar i = 0; i < ROWS; i++) begin : g_row
      logic [1:0]        rowStep;
      logic [ADDR_W-1:0] rowBase;
      always_comb begin
        rowStep    = window_step(i - int'(yLow) + LANES - 1, LANES);
        rowBase    = ADDR_W'(yHigh) + {{(ADDR_W-2){rowStep[1]}}, rowStep};
        rowTerm[i] = ADDR_W'(rowBase * ADDR_W'(ROW_STRIDE));
      end
    end
  end

  // stage 1: bank addresses, pattern and fractions
  logic [LB-1:0]     xLowA, yLowA, xLowD, yLowD;
  logic [FRAC_W-1:0] fracXA, fracYA, fracXD, fracYD;

  for (genvar i = 0; i < ROWS; i++) begin : g_addr_r
    for (genvar j = 0; j < LANES; j++) begin : g_addr_c
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          bankAddr[(i*LANES+j)*ADDR_W +: ADDR_W] <= '0;
        else if (strobe.launch)
          bankAddr[(i*LANES+j)*ADDR_W +: ADDR_W] <= rowTerm[i] + colTerm[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xLowA  <= '0;
      yLowA  <= '0;
      fracXA <= '0;
      fracYA <= '0;
      xLowD  <= '0;
      yLowD  <= '0;
      fracXD <= '0;
      fracYD <= '0;
    end else begin
      if (strobe.launch) begin
        xLowA  <= xLow;
        yLowA  <= yLow;
        fracXA <= reqX[FRAC_W-1:0];
        fracYA <= reqY[FRAC_W-1:0];
      end
      if (strobe.align) begin
        xLowD  <= xLowA;
        yLowD  <= yLowA;
        fracXD <= fracXA;
        fracYD <= fracYA;
      end
    end
  end

  // stage 2: rotate bank-ordered data into neighbour order
  logic [NBANK*DATA_W-1:0] rotated;

  for (genvar a = 0; a < ROWS; a++) begin : g_rot_r
    for (genvar b = 0; b < LANES; b++) begin : g_rot_c
      logic [LB-1:0] srcCol;
      logic [LB-1:0] srcRow;
      always_comb begin
        srcCol = xLowD + LB'(b) - LB'(1);
        srcRow = (ROWS == 1) ? '0 : yLowD + LB'(a) - LB'(1);
        rotated[(a*LANES+b)*DATA_W +: DATA_W] =
          bankData[(int'(srcRow)*LANES + int'(srcCol))*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSamples <= '0;
      outFracX   <= '0;
      outFracY   <= '0;
    end else if (strobe.publish) begin
      outSamples <= rotated;
      outFracX   <= fracXD;
      outFracY   <= fracYD;
    end
  end

endmodule

// File: rtl/nbr_fetch_top.sv
module nbr_fetch_top
  import nbr_fetch_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int DIMS       = 2,
  parameter int IDX_W      = 10,
  parameter int FRAC_W     = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int ROW_STRIDE = 64,
  localparam int ROWS      = (DIMS == 2) ? LANES : 1,
  localparam int NBANK     = ROWS * LANES,
  localparam int COORD_W   = IDX_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [COORD_W-1:0]      reqX,
  input  logic [COORD_W-1:0]      reqY,
  output logic                    bankRdEn,
  output logic [NBANK*ADDR_W-1:0] bankAddr,
  input  logic [NBANK*DATA_W-1:0] bankData,
  output logic                    outValid,
  output logic [NBANK*DATA_W-1:0] outSamples,
  output logic [FRAC_W-1:0]       outFracX,
  output logic [FRAC_W-1:0]       outFracY
);

  stage_strobe_t strobe;

  nbr_fetch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .bankRdEn (bankRdEn),
    .outValid (outValid)
  );

  nbr_fetch_dp #(
    .LANES      (LANES),
    .ROWS       (ROWS),
    .IDX_W      (IDX_W),
    .FRAC_W     (FRAC_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ROW_STRIDE (ROW_STRIDE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqX       (reqX),
    .reqY       (reqY),
    .bankAddr   (bankAddr),
    .bankData   (bankData),
    .outSamples (outSamples),
    .outFracX   (outFracX),
    .outFracY   (outFracY)
  );

endmodule

// File: rtl/nbr_fetch_chk.sv
module nbr_fetch_chk #(
  parameter int LANES      = 4,
  parameter int ROWS       = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 4,
  parameter int ROW_STRIDE = 64,
  localparam int NBANK     = ROWS * LANES
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    bankRdEn,
  input logic                    outValid,
  input logic [NBANK*ADDR_W-1:0] bankAddr,
  input logic [NBANK*DATA_W-1:0] outSamples,
  input logic [FRAC_W-1:0]       outFracX,
  input logic [FRAC_W-1:0]       outFracY
);

  localparam logic [ADDR_W-1:0] MINUS_ONE    = '1;
  localparam logic [ADDR_W-1:0] MINUS_STRIDE = ADDR_W'(0) - ADDR_W'(ROW_STRIDE);

  a_r2_read_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> bankRdEn);

  a_r9_no_spurious_read: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !bankRdEn);

  a_r6_out_after_read: assert property (@(posedge clk) disable iff (!rstN)
    bankRdEn |=> ##1 outValid);

  a_r9_no_spurious_out: assert property (@(posedge clk) disable iff (!rstN)
    !bankRdEn |=> ##1 !outValid);

  a_r9_hold_samples: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outSamples));

  a_r7_hold_frac: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outFracX) && $stable(outFracY)));

  // R3: within a bank row, the next bank column steps by 0 or -1
  for (genvar i = 0; i < ROWS; i++) begin : g_cs_r
    for (genvar j = 0; j < LANES - 1; j++) begin : g_cs_c
      logic [ADDR_W-1:0] colDiff;
      assign colDiff = bankAddr[(i*LANES+j+1)*ADDR_W +: ADDR_W]
                     - bankAddr[(i*LANES+j)*ADDR_W +: ADDR_W];
      a_r3_col_step: assert property (@(posedge clk) disable iff (!rstN)
        bankRdEn |-> (colDiff == '0 || colDiff == MINUS_ONE));
    end
  end

  // R4: down a bank column, the next bank row steps by 0 or -ROW_STRIDE
  for (genvar i = 0; i < ROWS - 1; i++) begin : g_rs_r
    for (genvar j = 0; j < LANES; j++) begin : g_rs_c
      logic [ADDR_W-1:0] rowDiff;
      assign rowDiff = bankAddr[((i+1)*LANES+j)*ADDR_W +: ADDR_W]
                     - bankAddr[(i*LANES+j)*ADDR_W +: ADDR_W];
      a_r4_row_step: assert property (@(posedge clk) disable iff (!rstN)
        bankRdEn |-> (rowDiff == '0 || rowDiff == MINUS_STRIDE));
    end
  end

endmodule

bind nbr_fetch_top nbr_fetch_chk #(
  .LANES      (LANES),
  .ROWS       (ROWS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .FRAC_W     (FRAC_W),
  .ROW_STRIDE (ROW_STRIDE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .bankRdEn   (bankRdEn),
  .outValid   (outValid),
  .bankAddr   (bankAddr),
  .outSamples (outSamples),
  .outFracX   (outFracX),
  .outFracY   (outFracY)
);

// File: tb/nbr_fetch_top_test.sv
`timescale 1ns/1ps
module nbr_fetch_top_test;

  localparam int LANES  = 4;
  localparam int IDX_W  = 10;
  localparam int FRAC_W = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int STRIDE = 64;
  localparam int NBANK  = LANES * LANES;
  localparam int CW     = IDX_W + FRAC_W;
  localparam int BURST  = 8;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    reqValid = 1'b0;
  logic [CW-1:0]           reqX = '0;
  logic [CW-1:0]           reqY = '0;
  logic                    bankRdEn;
  logic [NBANK*ADDR_W-1:0] bankAddr;
  logic [NBANK*DATA_W-1:0] bankData = '0;
  logic                    outValid;
  logic [NBANK*DATA_W-1:0] outSamples;
  logic [FRAC_W-1:0]       outFracX, outFracY;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  nbr_fetch_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqX(reqX), .reqY(reqY),
    .bankRdEn(bankRdEn), .bankAddr(bankAddr), .bankData(bankData),
    .outValid(outValid), .outSamples(outSamples),
    .outFracX(outFracX), .outFracY(outFracY)
  );

  // memory model: answers next edge with {bank index, address received}
  always @(posedge clk) begin
    if (bankRdEn)
      for (int k = 0; k < NBANK; k++)
        bankData[k*DATA_W +: DATA_W] <= {4'(k), bankAddr[k*ADDR_W +: ADDR_W]};
  end

  // expected sample word for neighbour (a,b) of integer position (xi,yi)
  function automatic logic [DATA_W-1:0] expWord(int xi, int yi, int a, int b);
    int r = yi - 1 + a + 16384;
    int c = xi - 1 + b + 16384;
    int bank = (r % LANES) * LANES + (c % LANES);
    int addr = ((r / LANES) * STRIDE + c / LANES) % 4096;
    return {4'(bank), 12'(addr)};
  endfunction

  function automatic int expBank(int xi, int yi, int a, int b);
    int r = yi - 1 + a + 16384;
    int c = xi - 1 + b + 16384;
    return (r % LANES) * LANES + (c % LANES);
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic string edgeTag(int xi, int yi, string base);
    if (xi < 1 || yi < 1 || xi > 1021 || yi > 1021) return {base, "/R8"};
    return base;
  endfunction

  // one isolated request, checked at every stage
  task automatic single(int xi, int yi, int fx, int fy);
    int bad;
    logic [DATA_W-1:0] w;
    @(negedge clk);
    reqValid = 1'b1;
    reqX = {10'(xi), 4'(fx)};
    reqY = {10'(yi), 4'(fy)};
    @(negedge clk);
    reqValid = 1'b0;
    check(bankRdEn == 1'b1, "R2 read strobe", bankRdEn, 1);
    bad = 0;
    for (int a = 0; a < LANES; a++)
      for (int b = 0; b < LANES; b++) begin
        w = expWord(xi, yi, a, b);
        if (bankAddr[expBank(xi, yi, a, b)*ADDR_W +: ADDR_W] != w[11:0]) bad++;
      end
    check(bad == 0, edgeTag(xi, yi, "R3/R4 bank addresses"), bad, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R6 not yet valid", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, "R6 valid two after read", outValid, 1);
    bad = 0;
    for (int a = 0; a < LANES; a++)
      for (int b = 0; b < LANES; b++)
        if (outSamples[(a*LANES+b)*DATA_W +: DATA_W] != expWord(xi, yi, a, b)) bad++;
    check(bad == 0, edgeTag(xi, yi, "R5 neighbour order"), bad, 0);
    check(outFracX == 4'(fx) && outFracY == 4'(fy), "R7 fractions",
          {outFracX, outFracY}, {4'(fx), 4'(fy)});
  endtask

  // burst collection
  int bx[BURST], by[BURST];
  logic [NBANK*DATA_W-1:0] got[BURST];
  int gotCnt = 0;
  bit collect = 0;

  always @(negedge clk) begin
    if (collect && outValid && gotCnt < BURST) begin
      got[gotCnt] <= outSamples;
      gotCnt <= gotCnt + 1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    logic [NBANK*DATA_W-1:0] held;
    logic [FRAC_W-1:0] hx, hy;
    int bad;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && bankRdEn == 1'b0, "R1 reset idle", {outValid, bankRdEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && bankRdEn == 1'b0, "R1 idle after release", {outValid, bankRdEn}, 0);

    // sweep every low-bit pattern in both dimensions at several bases
    foreach (bx[k]) begin end
    for (int base = 0; base < 3; base++)
      for (int yl = 0; yl < LANES; yl++)
        for (int xl = 0; xl < LANES; xl++) begin
          int kb = (base == 0) ? 0 : (base == 1) ? 37 : 255;
          int kr = (base == 0) ? 0 : (base == 1) ? 120 : 255;
          single(kb * LANES + xl, kr * LANES + yl, (xl * 5 + yl) % 16, (yl * 3 + 7) % 16);
        end

    // idle: nothing read, outputs held (R9)
    held = outSamples; hx = outFracX; hy = outFracY;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      check(bankRdEn == 1'b0 && outValid == 1'b0, "R9 no read or valid when idle",
            {bankRdEn, outValid}, 0);
      check(outSamples == held && outFracX == hx && outFracY == hy,
            "R9 outputs held", outSamples[15:0], held[15:0]);
    end

    // back-to-back requests (R6 throughput and ordering)
    collect = 1;
    for (int k = 0; k < BURST; k++) begin
      bx[k] = 300 + 3 * k;
      by[k] = 500 - 5 * k;
      @(negedge clk);
      reqValid = 1'b1;
      reqX = {10'(bx[k]), 4'(k)};
      reqY = {10'(by[k]), 4'(15 - k)};
    end
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    check(gotCnt == BURST, "R6 one result per request", gotCnt, BURST);
    for (int k = 0; k < BURST && k < gotCnt; k++) begin
      bad = 0;
      for (int a = 0; a < LANES; a++)
        for (int b = 0; b < LANES; b++)
          if (got[k][(a*LANES+b)*DATA_W +: DATA_W] != expWord(bx[k], by[k], a, b)) bad++;
      check(bad == 0, "R6/R5 burst order", bad, 0);
    end
    check(outFracX == 4'(BURST - 1) && outFracY == 4'(16 - BURST), "R7 last burst fractions",
          {outFracX, outFracY}, {4'(BURST - 1), 4'(16 - BURST)});

    done = 1;
    summary();
  end

endmodule